// File: doc/BRIEF.md
# Receive Cell Channel Dispatcher

This block sits at the front of a cell reassembly path. It takes the header of each received ATM cell, picks the reassembly channel the cell belongs to, and updates that channel's working state in an external channel table. The table has one entry per channel, and each entry holds eight 32-bit words. Word 3 holds the setup that the host writes once. Word 0 holds the working state that the block keeps up to date. The table index is the low ten bits of the VCI.

Cells whose PTI marks them as VC-level OAM traffic go to channel 0 whatever their VCI. Channel 0 treats every cell as a complete one-cell packet. On any channel, the first cell of a packet causes a reload: word 3 is read and its contents become the new word 0. Later cells of the same packet work from word 0 alone. For each cell the block reports the channel number, whether the cell starts a packet, and the updated working word. Cells whose VCI does not fit the table are dropped with an error flag.

The table is an external single-port RAM with a one-cycle read latency. Each cell is processed as a fixed sequence of RAM cycles. A new header is taken only while the block is idle.

Top module: `rx_chan_dispatch`

## Requirements
- R1: After reset, `hdr_ready` is 1, `out_valid` is 0 and `mem_we` is 0.
- R2: `hdr_ready` is 1 only while the block is idle. A header is taken on a cycle where `hdr_valid` and `hdr_ready` are both 1. `hdr_ready` then stays 0 until the cycle after the single-cycle `out_valid` pulse.
- R3: A cell with `hdr_pti[2:1]` = 2'b10 (OAM) uses channel 0, whatever its VCI.
- R4: A non-OAM cell uses channel `hdr_vci[9:0]`. If any of `hdr_vci[15:10]` is set, the cell is dropped. It then reports `out_err`=1, `out_chan`=0, `out_sop`=0 and `out_state`=0, and it makes no table write.
- R5: The table address is {channel, word index[2:0]}. Read data arrives on `mem_rdata` one cycle after the address.
- R6: Bit 31 of word 0 marks a packet in progress. If this bit is clear, or the channel is 0, the cell starts a packet. Word 3 is then read, and the result is word 3 with bit 31 replaced. `out_sop` is 1.
- R7: If bit 31 of word 0 is set and the channel is not 0, word 3 is not read. The result is word 0 with bit 31 replaced, and `out_sop` is 0.
- R8: In the result, bit 31 is the inverse of `hdr_pti[0]`, so a cell with `hdr_pti[0]`=1 ends the packet. On channel 0, bit 31 is always 0.
- R9: Each accepted cell that is not dropped makes exactly one table write. The write goes to word 0, and the written data equals the reported `out_state`.
- R10: Counting from the accepting clock edge, `out_valid` is sampled high after 4 edges for a continuation cell, after 5 for a packet start and after 1 for a dropped cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Block idle, header accepted |
| hdr_vci | input | 16 | Cell VCI |
| hdr_pti | input | 3 | Cell PTI |
| mem_addr | output | 13 | Table address {channel, word} |
| mem_we | output | 1 | Table write enable |
| mem_wdata | output | 32 | Table write data |
| mem_rdata | input | 32 | Table read data, one cycle after address |
| out_valid | output | 1 | Result pulse |
| out_chan | output | 10 | Selected channel |
| out_sop | output | 1 | Cell starts a packet |
| out_state | output | 32 | Updated working word |
| out_err | output | 1 | Cell dropped, VCI out of range |

## Verification
The hardest case is a continuation cell, because it needs word 0 of a channel to already carry the in-progress bit. The stimulus sets this up in two ways. Some table entries are preloaded with the bit set. Other channels get a start cell with PTI bit 0 clear, followed by a second cell on the same VCI. A cell with PTI bit 0 set then closes the packet, and a fourth cell confirms that the reload from word 3 happens again. Channel 0 is reached both by OAM cells with large VCIs and by a plain cell on VCI 0, to show that it never enters the in-progress state.

// File: rtl/rx_chan_dispatch.sv
module rx_chan_dispatch #(
  parameter int VCI_W  = 16,
  parameter int CHAN_W = 10,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hdr_valid,
  output logic                  hdr_ready,
  input  logic [VCI_W-1:0]      hdr_vci,
  input  logic [2:0]            hdr_pti,
  output logic [CHAN_W+2:0]     mem_addr,
  output logic                  mem_we,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic                  out_valid,
  output logic [CHAN_W-1:0]     out_chan,
  output logic                  out_sop,
  output logic [WORD_W-1:0]     out_state,
  output logic                  out_err
);
  localparam int TOP = WORD_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_CK0, S_CK3, S_WR, S_DONE} st_t;
  st_t st;

  logic [CHAN_W-1:0] chan_q;
  logic              pti0_q, sop_q;
  logic [WORD_W-1:0] word_q;

  wire is_oam   = hdr_pti[2:1] == 2'b10;
  wire bad_vci  = !is_oam && (|hdr_vci[VCI_W-1:CHAN_W]);
  wire ch0      = chan_q == '0;
  wire starts   = ch0 || !mem_rdata[TOP];
  wire [WORD_W-1:0] new_word = {~pti0_q & ~ch0, word_q[TOP-1:0]};

  assign hdr_ready = st == S_IDLE;
  assign out_valid = st == S_DONE;
  assign mem_we    = st == S_WR;
  assign mem_wdata = new_word;
  assign mem_addr  = {chan_q, (st == S_CK0 && starts) ? 3'd3 : 3'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      chan_q    <= '0;
      pti0_q    <= 1'b0;
      sop_q     <= 1'b0;
      word_q    <= '0;
      out_chan  <= '0;
      out_sop   <= 1'b0;
      out_state <= '0;
      out_err   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (hdr_valid) begin
          chan_q <= is_oam ? '0 : hdr_vci[CHAN_W-1:0];
          pti0_q <= hdr_pti[0];
          if (bad_vci) begin
            out_err   <= 1'b1;
            out_chan  <= '0;
            out_sop   <= 1'b0;
            out_state <= '0;
            st        <= S_DONE;
          end else begin
            out_err <= 1'b0;
            st      <= S_RD0;
          end
        end
        S_RD0: st <= S_CK0;
        S_CK0: begin
          word_q <= mem_rdata;
          sop_q  <= starts;
          st     <= starts ? S_CK3 : S_WR;
        end
        S_CK3: begin
          word_q <= mem_rdata;
          st     <= S_WR;
        end
        S_WR: begin
          out_state <= new_word;
          out_chan  <= chan_q;
          out_sop   <= sop_q;
          st        <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> !hdr_ready);
  // R2
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> hdr_ready && !out_valid);
  // R4
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready && hdr_pti[2:1] != 2'b10 && (|hdr_vci[VCI_W-1:CHAN_W])
    |=> out_valid && out_err);
  // R9
  write_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[2:0] == 3'd0);
  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we && out_valid && out_state == $past(mem_wdata));
  // R8
  chan0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && out_chan == '0 |-> out_sop && !out_state[TOP]);
endmodule

// File: tb/test_rx_chan_dispatch.sv
module test_rx_chan_dispatch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic hdr_ready;
  logic [15:0] hdr_vci = '0;
  logic [2:0]  hdr_pti = '0;
  logic [12:0] mem_addr;
  logic        mem_we;
  logic [31:0] mem_wdata, mem_rdata;
  logic        out_valid, out_sop, out_err;
  logic [9:0]  out_chan;
  logic [31:0] out_state;

  int checks = 0, errors = 0;
  int n_wr = 0, n_rd3 = 0, bad_addr = 0;
  logic [12:0] wr_addr;
  logic [31:0] wr_data;

  always #10 clk = ~clk;

  rx_chan_dispatch i_rx_chan_dispatch (
    .clk, .rst_n, .hdr_valid, .hdr_ready, .hdr_vci, .hdr_pti,
    .mem_addr, .mem_we, .mem_wdata, .mem_rdata,
    .out_valid, .out_chan, .out_sop, .out_state, .out_err);

  logic [31:0] mem [0:127];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++)
        mem[i] <= (i % 8 == 3) ? 32'h0000_1000 + 32'(i / 8) :
                  (i == 5*8)   ? 32'h8000_0055 : 32'h0;
      mem_rdata <= '0;
    end else begin
      if (mem_addr[12:7] != 0) bad_addr++;
      if (mem_we) begin
        mem[mem_addr[6:0]] <= mem_wdata;
        n_wr++; wr_addr = mem_addr; wr_data = mem_wdata;
      end else if (mem_addr[2:0] == 3'd3) n_rd3++;
      mem_rdata <= mem[mem_addr[6:0]];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] vci; logic [2:0] pti; logic [9:0] chan; logic sop;
    logic [31:0] state; logic err; logic [3:0] lat;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{16'd5,      3'b000, 10'd5, 1'b0, 32'h8000_0055, 1'b0, 4'd4},
    '{16'd5,      3'b001, 10'd5, 1'b0, 32'h0000_0055, 1'b0, 4'd4},
    '{16'd5,      3'b000, 10'd5, 1'b1, 32'h8000_1005, 1'b0, 4'd5},
    '{16'd3,      3'b001, 10'd3, 1'b1, 32'h0000_1003, 1'b0, 4'd5},
    '{16'h0407,   3'b100, 10'd0, 1'b1, 32'h0000_1000, 1'b0, 4'd5},
    '{16'h0400,   3'b000, 10'd0, 1'b0, 32'h0000_0000, 1'b1, 4'd1},
    '{16'd7,      3'b101, 10'd0, 1'b1, 32'h0000_1000, 1'b0, 4'd5},
    '{16'd7,      3'b010, 10'd7, 1'b1, 32'h8000_1007, 1'b0, 4'd5},
    '{16'd7,      3'b011, 10'd7, 1'b0, 32'h0000_1007, 1'b0, 4'd4},
    '{16'd0,      3'b000, 10'd0, 1'b1, 32'h0000_1000, 1'b0, 4'd5},
    '{16'd6,      3'b110, 10'd6, 1'b1, 32'h8000_1006, 1'b0, 4'd5},
    '{16'd6,      3'b000, 10'd6, 1'b0, 32'h8000_1006, 1'b0, 4'd4}
  };

  task automatic run_cell(vec_t v);
    int lat = 1;
    logic ready_low = 1'b1;
    @(negedge clk);
    hdr_vci = v.vci; hdr_pti = v.pti; hdr_valid = 1'b1;
    n_wr = 0; n_rd3 = 0;
    chk("R2 ready before take", 32'(hdr_ready), 32'd1);
    @(negedge clk);
    hdr_valid = 1'b0;
    while (!out_valid && lat < 20) begin
      if (hdr_ready) ready_low = 1'b0;
      @(negedge clk); lat++;
    end
    chk("R2 ready low while busy", 32'(ready_low), 32'd1);
    chk("R10 latency", 32'(lat), 32'(v.lat));
    chk("R3/R4 channel", 32'(out_chan), 32'(v.chan));
    chk("R4 error flag", 32'(out_err), 32'(v.err));
    chk("R6/R7 sop", 32'(out_sop), 32'(v.sop));
    chk("R8 state word", out_state, v.state);
    chk("R6/R7 word3 read", 32'(n_rd3), 32'(v.sop && !v.err));
    chk("R9 write count", 32'(n_wr), 32'(!v.err));
    if (!v.err) begin
      chk("R5 R9 write addr", 32'(wr_addr), {19'd0, v.chan, 3'd0});
      chk("R9 write data", wr_data, out_state);
    end
    @(negedge clk);
    chk("R2 ready after result", 32'(hdr_ready), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", 32'(hdr_ready), 32'd1);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 mem_we", 32'(mem_we), 32'd0);
    rst_n = 1'b1;
    foreach (VECS[k]) run_cell(VECS[k]);
    // R4: dropped OAM-looking? no: big VCI with user PTI 011 leaves channel 3 untouched
    run_cell('{16'hFC03, 3'b011, 10'd0, 1'b0, 32'h0, 1'b1, 4'd1});
    run_cell('{16'd3, 3'b000, 10'd3, 1'b1, 32'h8000_1003, 1'b0, 4'd5});
    chk("R5 address range", 32'(bad_addr), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule